// File: doc/BRIEF.md
# Center-Aligned Three-Phase PWM Generator with Deadtime

This block drives a three-phase power inverter. For each phase A, B and C it produces one high-side and one low-side gate signal. The high-side pulse sits in the middle of each switching cycle and the low-side pulse fills the ends of the cycle. One free-running counter in the peripheral clock domain sets the switching cycle. All switching edges come from three numbers: the cycle length, a deadtime and the phase duty. So control software only has to write three duty values per cycle.

Inside a cycle, the high-side on-time is cut back by the deadtime at both of its edges. This leaves a guard gap each time the pair changes over. Any pulse narrower than a programmable minimum width is removed, and the pair then stays in the state it was in. At the cycle boundary no gap is inserted, so the duty range must be limited by whoever programs the block. A one-clock sync pulse marks the first count of every cycle. Every input value is taken only in the clock that starts a new cycle.

Top module: `pwm3_center`

## Requirements
- R1: A cycle lasts `period_i` clocks, with the count running 0 to period-1, for any period of 2 or more. `sync_o` is high for exactly the one clock with count 0.
- R2: In every clock, the high and low output of a phase are never both 1.
- R3: Let lo = floor((T-d)/2) and hi = T-lo, where T is the period and d is the duty. In the normal case, the high output is 1 for counts lo+D through hi-D-1, where D is the deadtime. The low output is 1 for counts below lo and for counts from hi upward.
- R4: If the high on-width hi-lo-2D is zero or less, or is smaller than the minimum pulse P, the high output stays 0 and the low output stays 1 for the whole cycle.
- R5: A normal high pulse is centred in the cycle. Its first and last high counts add up to T-1.
- R6: A duty of 0 gives high 0 and low 1 for the whole cycle. A duty equal to or greater than the period gives high 1 and low 0 for the whole cycle.
- R7: Changes to period, deadtime, minimum pulse or duty in the middle of a cycle have no effect until the next cycle starts.
- R8: While `rst` is high, all six gate outputs and `sync_o` are 0.
- R9: If the high pulse is kept but the low on-width 2*lo is zero or smaller than P, the high output stays 1 and the low output stays 0 for the whole cycle.
- R10: No gap is inserted at the cycle boundary. A low output may be 1 in the first clock of a cycle even when the high output was 1 in the last clock of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | 12 | Cycle length in clocks |
| deadtime_i | input | 10 | Guard time in clocks at each in-cycle transition |
| minpulse_i | input | 10 | Narrowest pulse that is allowed out |
| duty_a_i | input | 12 | Phase A high-side duty in clocks |
| duty_b_i | input | 12 | Phase B high-side duty in clocks |
| duty_c_i | input | 12 | Phase C high-side duty in clocks |
| sync_o | output | 1 | One-clock pulse at count 0 |
| ah_o | output | 1 | Phase A high-side gate |
| al_o | output | 1 | Phase A low-side gate |
| bh_o | output | 1 | Phase B high-side gate |
| bl_o | output | 1 | Phase B low-side gate |
| ch_o | output | 1 | Phase C high-side gate |
| cl_o | output | 1 | Phase C low-side gate |

## Verification
The case that is hardest to reach from the ports is the boundary overlap. To see it, a phase must spend a whole cycle fully on and then move to a normal duty in the very next cycle. The stimulus first holds every duty at the period. It then writes a smaller duty for phase A in the middle of a cycle. The change only takes effect at the next start, so the following sync clock is the one where the low output rises right after a high clock. The same mid-cycle writes, including a change of period, show that nothing takes effect early. Duties are chosen so that the narrow-pulse cases land exactly on and just below the minimum width.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;

    localparam int CW  = 12;      // period and duty width
    localparam int DW  = 10;      // deadtime and minimum pulse width
    localparam int EW  = CW + 2;  // working width for edge arithmetic
    localparam int NPH = 3;       // number of phases

    typedef enum logic [1:0] {
        MODE_OFF = 2'd0,
        MODE_ON  = 2'd1,
        MODE_RUN = 2'd2
    } pair_mode_e;

    typedef struct packed {
        pair_mode_e     mode;
        logic [EW-1:0]  rise;      // first high count
        logic [EW-1:0]  fall;      // first count after the high pulse
        logic [EW-1:0]  lo_end;    // low side off from this count
        logic [EW-1:0]  lo_start;  // low side on again from this count
    } pair_edges_t;

    function automatic pair_edges_t calc_edges(
        input logic [CW-1:0] per,
        input logic [CW-1:0] duty,
        input logic [DW-1:0] dead,
        input logic [DW-1:0] minp
    );
        logic [EW-1:0]   per_e;
        logic [EW-1:0]   duty_e;
        logic [EW-1:0]   dead_e;
        logic [EW-1:0]   minp_e;
        logic [EW-1:0]   lo;
        logic [EW-1:0]   hi;
        logic [EW-1:0]   wl;
        logic signed [EW:0] wh;
        pair_edges_t     e;
        per_e  = EW'(per);
        duty_e = EW'(duty);
        dead_e = EW'(dead);
        minp_e = EW'(minp);
        lo = '0;
        if (duty_e < per_e)
            lo = (per_e - duty_e) >> 1;
        hi = per_e - lo;
        wh = $signed({1'b0, hi - lo}) - $signed({1'b0, dead_e << 1});
        wl = lo << 1;
        e.rise     = lo + dead_e;
        e.fall     = hi - dead_e;
        e.lo_end   = lo;
        e.lo_start = hi;
        if (duty_e == '0)
            e.mode = MODE_OFF;
        else if (duty_e >= per_e)
            e.mode = MODE_ON;
        else if ((wh <= 0) || (wh < $signed({1'b0, minp_e})))
            e.mode = MODE_OFF;
        else if ((lo == '0) || (wl < minp_e))
            e.mode = MODE_ON;
        else
            e.mode = MODE_RUN;
        return e;
    endfunction

endpackage

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
    import pwm3_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] period_i,
    output logic [CW-1:0] cnt_nxt_o,
    output logic          wrap_o,
    output logic          sync_o
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] per_q;
    logic          sync_q;

    always_comb begin
        wrap_o    = ({1'b0, cnt_q} + (CW+1)'(1)) >= {1'b0, per_q};
        cnt_nxt_o = wrap_o ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            per_q  <= '0;
            sync_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_nxt_o;
            sync_q <= wrap_o;
            if (wrap_o)
                per_q <= period_i;
        end
    end

    assign sync_o = sync_q;

    // R1: the count stays inside the active period
    p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (rst)
        (per_q >= CW'(2)) |-> (cnt_q < per_q));

    // R1: sync lasts a single clock
    p_sync_single_r1: assert property (@(posedge clk) disable iff (rst)
        (sync_q && per_q >= CW'(2)) |=> !sync_q);

    // R7: the active period only moves together with a cycle start
    p_period_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !sync_q |-> $stable(per_q));

endmodule

// File: rtl/pwm3_edge_calc.sv
module pwm3_edge_calc
    import pwm3_pkg::*;
(
    input  logic [CW-1:0] per_i,
    input  logic [CW-1:0] duty_i,
    input  logic [DW-1:0] dead_i,
    input  logic [DW-1:0] minp_i,
    output pair_edges_t   edges_o
);

    always_comb begin
        edges_o = calc_edges(per_i, duty_i, dead_i, minp_i);
    end

endmodule

// File: rtl/pwm3_phase_out.sv
module pwm3_phase_out
    import pwm3_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wrap_i,
    input  logic [CW-1:0] cnt_nxt_i,
    input  pair_edges_t   edges_i,
    input  logic [DW-1:0] dead_i,
    output logic          hi_o,
    output logic          lo_o
);

    pair_edges_t   edges_q;
    pair_edges_t   sel;
    logic [DW-1:0] dead_q;
    logic [EW-1:0] pos;
    logic          hi_d;
    logic          lo_d;

    always_comb begin
        sel = wrap_i ? edges_i : edges_q;
        pos = EW'(cnt_nxt_i);
        hi_d = 1'b0;
        lo_d = 1'b0;
        case (sel.mode)
            MODE_OFF: begin
                hi_d = 1'b0;
                lo_d = 1'b1;
            end
            MODE_ON: begin
                hi_d = 1'b1;
                lo_d = 1'b0;
            end
            MODE_RUN: begin
                hi_d = (pos >= sel.rise) && (pos < sel.fall);
                lo_d = (pos < sel.lo_end) || (pos >= sel.lo_start);
            end
            default: begin
                hi_d = 1'b0;
                lo_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            edges_q <= '{mode: MODE_OFF, default: '0};
            dead_q  <= '0;
            hi_o    <= 1'b0;
            lo_o    <= 1'b0;
        end else begin
            if (wrap_i) begin
                edges_q <= edges_i;
                dead_q  <= dead_i;
            end
            hi_o <= hi_d;
            lo_o <= lo_d;
        end
    end

    // R2: complementary outputs never overlap
    p_no_overlap_r2: assert property (@(posedge clk) disable iff (rst)
        !(hi_o && lo_o));

    // R3: inside a cycle the high side turns on only after the low side was off
    p_dead_before_hi_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(hi_o) && !$past(wrap_i) && dead_q != '0) |-> !$past(lo_o));

    // R3: inside a cycle the low side turns on only after the high side was off
    p_dead_before_lo_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(lo_o) && !$past(wrap_i) && dead_q != '0) |-> !$past(hi_o));

    // R6: a full-on pair holds high and keeps the low side off
    p_full_on_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(wrap_i) && edges_q.mode == MODE_ON) |-> (hi_o && !lo_o));

endmodule

// File: rtl/pwm3_center.sv
module pwm3_center
    import pwm3_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] period_i,
    input  logic [DW-1:0] deadtime_i,
    input  logic [DW-1:0] minpulse_i,
    input  logic [CW-1:0] duty_a_i,
    input  logic [CW-1:0] duty_b_i,
    input  logic [CW-1:0] duty_c_i,
    output logic          sync_o,
    output logic          ah_o,
    output logic          al_o,
    output logic          bh_o,
    output logic          bl_o,
    output logic          ch_o,
    output logic          cl_o
);

    logic [CW-1:0] cnt_nxt;
    logic          wrap;
    logic [CW-1:0] duty_arr [NPH];
    pair_edges_t   edges    [NPH];
    logic          hi_arr   [NPH];
    logic          lo_arr   [NPH];

    assign duty_arr[0] = duty_a_i;
    assign duty_arr[1] = duty_b_i;
    assign duty_arr[2] = duty_c_i;

    pwm3_timebase u_tb (
        .clk       (clk),
        .rst       (rst),
        .period_i  (period_i),
        .cnt_nxt_o (cnt_nxt),
        .wrap_o    (wrap),
        .sync_o    (sync_o)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        pwm3_edge_calc u_calc (
            .per_i   (period_i),
            .duty_i  (duty_arr[g]),
            .dead_i  (deadtime_i),
            .minp_i  (minpulse_i),
            .edges_o (edges[g])
        );

        pwm3_phase_out u_out (
            .clk       (clk),
            .rst       (rst),
            .wrap_i    (wrap),
            .cnt_nxt_i (cnt_nxt),
            .edges_i   (edges[g]),
            .dead_i    (deadtime_i),
            .hi_o      (hi_arr[g]),
            .lo_o      (lo_arr[g])
        );
    end

    assign ah_o = hi_arr[0];
    assign al_o = lo_arr[0];
    assign bh_o = hi_arr[1];
    assign bl_o = lo_arr[1];
    assign ch_o = hi_arr[2];
    assign cl_o = lo_arr[2];

endmodule

// File: tb/pwm3_center_bench.sv
`timescale 1ns/1ps
module pwm3_center_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] period_i = '0;
    logic [9:0]  deadtime_i = '0;
    logic [9:0]  minpulse_i = '0;
    logic [11:0] duty_a_i = '0;
    logic [11:0] duty_b_i = '0;
    logic [11:0] duty_c_i = '0;
    logic sync_o, ah_o, al_o, bh_o, bl_o, ch_o, cl_o;

    always #2.5 clk = ~clk;

    pwm3_center u_pwm3_center (
        .clk(clk), .rst(rst), .period_i(period_i), .deadtime_i(deadtime_i),
        .minpulse_i(minpulse_i), .duty_a_i(duty_a_i), .duty_b_i(duty_b_i),
        .duty_c_i(duty_c_i), .sync_o(sync_o), .ah_o(ah_o), .al_o(al_o),
        .bh_o(bh_o), .bl_o(bl_o), .ch_o(ch_o), .cl_o(cl_o)
    );

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R8";
    int    cyc = 0;
    bit    prev_ah = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference of one phase pair at count c
    function automatic void exp_pair(input int T, input int d, input int D,
                                     input int P, input int c,
                                     output bit h, output bit l);
        int lo, hi, won;
        if (d == 0) begin h = 0; l = 1; end
        else if (d >= T) begin h = 1; l = 0; end
        else begin
            lo  = (T - d) / 2;
            hi  = T - lo;
            won = hi - lo - 2 * D;
            if (won <= 0 || won < P) begin h = 0; l = 1; end
            else if (lo == 0 || 2 * lo < P) begin h = 1; l = 0; end
            else begin
                h = (c >= lo + D) && (c < hi - D);
                l = (c < lo) || (c >= hi);
            end
        end
    endfunction

    // reference state, advanced on each rising edge
    int rT = 0, rD = 0, rP = 0, rc = 0;
    int rd [3];
    bit rsync = 0, rvalid = 0, started = 0;

    always @(posedge clk) begin
        if (rst) begin
            rvalid = 0; rT = 0; rc = 0; rsync = 0;
        end else begin
            if (rc + 1 >= rT) begin
                rc = 0; rT = int'(period_i); rD = int'(deadtime_i); rP = int'(minpulse_i);
                rd[0] = int'(duty_a_i); rd[1] = int'(duty_b_i); rd[2] = int'(duty_c_i);
                rsync = 1;
            end else begin
                rc++; rsync = 0;
            end
            rvalid = 1;
        end
        started = 1;
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        bit eh [3];
        bit el [3];
        bit ah [3];
        bit al [3];
        if (started) begin
            ah[0] = ah_o; al[0] = al_o; ah[1] = bh_o; al[1] = bl_o; ah[2] = ch_o; al[2] = cl_o;
            for (int p = 0; p < 3; p++) begin
                if (rvalid) exp_pair(rT, rd[p], rD, rP, rc, eh[p], el[p]);
                else begin eh[p] = 0; el[p] = 0; end
                chk(ah[p] == eh[p], cur_req, $sformatf("phase %0d high at count %0d", p, rc), ah[p], eh[p]);
                chk(al[p] == el[p], cur_req, $sformatf("phase %0d low at count %0d", p, rc), al[p], el[p]);
                chk(!(ah[p] && al[p]), "R2", $sformatf("phase %0d overlap", p), 1, 0);
            end
            chk(sync_o == (rvalid && rsync), (rvalid ? "R1" : cur_req), "sync", sync_o, rvalid && rsync);
            prev_ah = ah_o;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic set_regs(input int T, input int D, input int P,
                            input int a, input int b, input int c);
        period_i = 12'(T); deadtime_i = 10'(D); minpulse_i = 10'(P);
        duty_a_i = 12'(a); duty_b_i = 12'(b); duty_c_i = 12'(c);
    endtask

    task automatic wait_sync();
        do @(negedge clk); while (!sync_o);
    endtask

    // R5 and R1: measure one cycle of phase A starting at a sync
    task automatic measure(input int T, input int ef, input int el);
        int first = -1;
        int last = -1;
        wait_sync();
        for (int i = 0; i < T; i++) begin
            if (ah_o) begin
                if (first < 0) first = i;
                last = i;
            end
            @(negedge clk);
        end
        chk(sync_o == 1'b1, "R1", "sync after period clocks", sync_o, 1);
        chk(first == ef, "R5", "first high count", first, ef);
        chk(last == el, "R5", "last high count", last, el);
        chk(first + last == T - 1, "R5", "centre sum", first + last, T - 1);
    endtask

    initial begin
        // R8: reset holds every output low
        set_regs(40, 3, 2, 20, 10, 30);
        cur_req = "R8";
        repeat (4) @(negedge clk);
        chk({sync_o, ah_o, al_o, bh_o, bl_o, ch_o, cl_o} == 7'b0, "R8", "outputs in reset",
            int'({sync_o, ah_o, al_o, bh_o, bl_o, ch_o, cl_o}), 0);
        #1 rst = 1'b0;

        // R3: normal edges with deadtime
        cur_req = "R3";
        repeat (100) @(negedge clk);
        measure(40, 13, 26);
        measure(40, 13, 26);

        // R3: zero deadtime, zero minimum, odd period
        set_regs(41, 0, 0, 15, 1, 29);
        repeat (130) @(negedge clk);
        measure(41, 13, 27);

        // R6: full off and full on
        cur_req = "R6";
        #1 set_regs(40, 3, 2, 0, 40, 50);
        repeat (100) @(negedge clk);

        // R4: high pulse at and below the minimum width
        cur_req = "R4";
        #1 set_regs(40, 3, 6, 12, 10, 30);
        repeat (100) @(negedge clk);

        // R9: low pulse below the minimum width
        cur_req = "R9";
        #1 set_regs(40, 3, 6, 12, 36, 20);
        repeat (100) @(negedge clk);

        // R7: mid-cycle writes wait for the next cycle start
        cur_req = "R7";
        #1 set_regs(40, 2, 0, 16, 24, 8);
        repeat (90) @(negedge clk);
        wait_sync();
        repeat (15) @(negedge clk);
        #1 set_regs(64, 1, 0, 32, 50, 5);
        repeat (10) @(negedge clk);
        chk(sync_o == 1'b0, "R7", "no early cycle start", sync_o, 0);
        measure(64, 17, 46);

        // R10: leaving full-on has no gap at the boundary
        cur_req = "R10";
        #1 set_regs(40, 3, 0, 40, 40, 40);
        repeat (90) @(negedge clk);
        wait_sync();
        repeat (5) @(negedge clk);
        #1 set_regs(40, 3, 0, 20, 40, 40);
        wait_sync();
        chk(prev_ah == 1'b1, "R10", "high in last clock of full-on cycle", prev_ah, 1);
        chk(al_o == 1'b1, "R10", "low at first clock of next cycle", al_o, 1);
        repeat (60) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule